// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of five prioritised software contexts ("localities", numbered 0 to 4, 4 the highest) owns a shared command interface. Every locality sees its own one-byte access register. The locality being addressed is taken from the address bits above a 4 KB register window, and the access register sits at byte offset 0 of that window. Through this register a locality can ask for ownership, hand it back, take it forcibly from a lower-numbered owner, and acknowledge that it was itself overridden.

A change of owner may need the command engine to stop work that is in flight first. When the command engine reports that it is busy at the moment a handover is decided, the arbiter raises an abort request, names the locality being aborted, and keeps the current owner in place until a one-cycle abort-done pulse arrives. When the engine is idle, the handover happens on the same clock edge as the write. Each real change of owner produces a one-cycle locality-changed pulse.

Top module: `loc_arb_top`

## Requirements
- R1: After reset no locality is active: `active_valid` is 0, `active_loc` and `abort_loc` read 7 (the "none" code), `abort_req` is 0, and every access register reads 0x80 with bit 0 equal to `est_in`.
- R2: A read of the access register of locality L returns bit 7 = 1, bit 5 = (L is the owner), bit 4 = L's overridden flag, bit 3 = 0 always, bit 2 = 1 when any locality other than L has a waiting request, bit 1 = L's waiting request, bit 0 = `est_in`; bit 6 is 0.
- R3: Writing bit 1 (request) while no locality is active and no handover is pending makes the writer the owner on that edge, with `loc_changed` high for exactly the next cycle.
- R4: Writing bit 1 while a different locality owns the interface, or while a handover is pending, records a waiting request for the writer instead of granting.
- R5: When the owner writes bit 5 (release), the highest-numbered locality with a waiting request is chosen as the next owner; with none waiting, no locality is active afterwards.
- R6: When a locality that is not the owner writes bit 5, its own waiting request is withdrawn.
- R7: A write with bit 3 (seize) is accepted only if no locality is active or the writer's number exceeds the owner's, and only if neither the writer nor any higher locality already has a seize outstanding; acceptance cancels the outstanding seizes of all lower localities and starts a handover to the writer.
- R8: On a handover caused by a seize, the previous owner's overridden flag (bit 4) is set and its waiting request is kept; on any other handover the previous owner's waiting request is cleared.
- R9: The new owner's waiting request and outstanding seize are cleared, and `loc_changed` pulses only when the owner actually changes.
- R10: Writing 1 to bit 4 clears the writer's overridden flag; in a write that has bit 3 set, bits 1 and 5 are disregarded.
- R11: Writes addressed to locality 4 take effect only when `hw_src` is 1.
- R12: If `cmd_busy` is 1 when a handover starts, `abort_req` rises with `abort_loc` = current owner (7 if none), the owner stays unchanged until an `abort_done` pulse, and the handover then completes with `abort_req` low and `abort_loc` back to 7; an accepted seize while pending retargets the handover, a release by the owner while pending is ignored, and a write in the same cycle as `abort_done` is dropped.
- R13: Writes to any offset other than 0, or to localities 5 to 7, have no effect; reads of them return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 15 | Byte address; bits 14:12 select the locality, bits 11:0 the offset |
| wdata | input | 8 | Write data byte |
| hw_src | input | 1 | Marks the current write as coming from the hardware side |
| est_in | input | 1 | Value reflected in bit 0 of every access register read |
| cmd_busy | input | 1 | Command engine has work in flight |
| abort_done | input | 1 | One-cycle pulse: requested abort has finished |
| rdata | output | 8 | Read data for the addressed register (combinational) |
| active_valid | output | 1 | Some locality owns the interface |
| active_loc | output | 3 | Owning locality, 7 when none |
| loc_changed | output | 1 | One-cycle pulse after the owner changes |
| abort_req | output | 1 | A handover waits for the command engine to abort |
| abort_loc | output | 3 | Locality whose command is being aborted, 7 when none |

## Verification
The assertions take `abort_done` to be a single-cycle pulse that only arrives while `abort_req` is high, and take `cmd_busy` to be sampled only at the edge where a handover starts. The stimulus drives `abort_done` exclusively in cycles where it has seen `abort_req` asserted at the port, and otherwise leaves it low, while `cmd_busy`, `hw_src`, the addressed locality and the written byte vary freely. Directed sequences cover the seize ordering rules, retargeting during a pending abort, and the hardware-side gate for locality 4 before a long randomised run.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;

  localparam int LOC_W = 3;
  typedef logic [LOC_W-1:0] loc_t;
  localparam loc_t LOC_NONE = '1;

  // access byte bit positions (software visible layout)
  localparam int B_VALID  = 7;
  localparam int B_ACTIVE = 5;
  localparam int B_SEIZED = 4;
  localparam int B_SEIZE  = 3;
  localparam int B_PEND   = 2;
  localparam int B_REQ    = 1;
  localparam int B_EST    = 0;

  // highest index with a set bit, LOC_NONE when empty
  function automatic loc_t pick_top(input logic [7:0] v);
    loc_t r;
    r = LOC_NONE;
    for (int i = 0; i < 7; i++) begin
      if (v[i]) r = loc_t'(i);
    end
    return r;
  endfunction

  // any bit set strictly above index l
  function automatic logic any_above(input logic [7:0] v, input loc_t l);
    logic r;
    r = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i > int'(l)) r = r | v[i];
    end
    return r;
  endfunction

  // any bit set other than index l
  function automatic logic others_set(input logic [7:0] v, input loc_t l);
    logic r;
    r = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i != int'(l)) r = r | v[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/loc_arb_decode.sv
module loc_arb_decode
  import loc_arb_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int LOC_LSB = 12,
  parameter int NUM_LOC = 5,
  parameter int HW_LOC  = 4
) (
  input  logic              wr_en,
  input  logic              hw_src,
  input  logic [ADDR_W-1:0] addr,
  output loc_t              sel_loc,
  output logic              reg_hit,
  output logic              acc_wr
);

  localparam loc_t LAST_LOC = loc_t'(NUM_LOC - 1);
  localparam loc_t HW_ID    = loc_t'(HW_LOC);

  logic [LOC_LSB-1:0] offs;
  logic               hw_block;

  assign sel_loc  = addr[ADDR_W-1:LOC_LSB];
  assign offs     = addr[LOC_LSB-1:0];
  assign reg_hit  = (offs == '0) && (sel_loc <= LAST_LOC);
  assign hw_block = (sel_loc == HW_ID) && !hw_src;
  assign acc_wr   = wr_en && reg_hit && !hw_block;

endmodule

// File: rtl/loc_arb_core.sv
module loc_arb_core
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_wr,
  input  loc_t               wr_loc,
  input  logic [7:0]         wdata,
  input  logic               cmd_busy,
  input  logic               abort_done,
  output loc_t               act_q,
  output logic [NUM_LOC-1:0] req_q,
  output logic [NUM_LOC-1:0] seized_q,
  output logic               chg_q,
  output loc_t               pnext_q,
  output loc_t               pab_q
);

  logic [NUM_LOC-1:0] seize_q;
  logic [NUM_LOC-1:0] n_req, n_seize, n_seized;
  loc_t               n_act, n_pnext, n_pab;
  logic               n_chg;

  logic [7:0] req8, seize8, v;
  logic       pend, done_take, seize_ok, keep;
  logic       st_go, ho_go;
  loc_t       st_tgt, ho_tgt, top_req;

  assign req8      = 8'(req_q);
  assign seize8    = 8'(seize_q);
  assign pend      = (pnext_q != LOC_NONE);
  assign done_take = pend && abort_done;
  assign top_req   = pick_top(req8);
  assign seize_ok  = ((act_q == LOC_NONE) || (wr_loc > act_q)) &&
                     !seize8[wr_loc] && !any_above(seize8, wr_loc);

  always_comb begin
    n_req    = req_q;
    n_seize  = seize_q;
    n_seized = seized_q;
    n_act    = act_q;
    n_pnext  = pnext_q;
    n_pab    = pab_q;
    n_chg    = 1'b0;
    keep     = 1'b1;
    st_go    = 1'b0;
    st_tgt   = LOC_NONE;
    ho_go    = 1'b0;
    ho_tgt   = act_q;
    v        = wdata;
    if (v[B_SEIZE]) begin
      v[B_REQ]    = 1'b0;
      v[B_ACTIVE] = 1'b0;
    end

    if (done_take) begin
      ho_go   = 1'b1;
      ho_tgt  = pnext_q;
      n_pnext = LOC_NONE;
      n_pab   = LOC_NONE;
    end else if (acc_wr) begin
      // release or withdraw
      if (v[B_ACTIVE]) begin
        if (act_q == wr_loc) begin
          if (!pend) begin
            if (top_req != LOC_NONE) begin
              keep   = 1'b0;
              st_go  = 1'b1;
              st_tgt = top_req;
            end else begin
              ho_tgt = LOC_NONE;
            end
          end
        end else begin
          n_req[wr_loc] = 1'b0;
        end
      end
      // acknowledge override
      if (v[B_SEIZED]) n_seized[wr_loc] = 1'b0;
      // forcible takeover
      if (v[B_SEIZE] && seize_ok) begin
        for (int c = 0; c < NUM_LOC; c++) begin
          if (loc_t'(c) < wr_loc) n_seize[c] = 1'b0;
        end
        n_seize[wr_loc] = 1'b1;
        keep   = 1'b0;
        st_go  = 1'b1;
        st_tgt = wr_loc;
      end
      // ask for use
      if (v[B_REQ] && (act_q != wr_loc)) begin
        if ((act_q != LOC_NONE) || pend) n_req[wr_loc] = 1'b1;
        else ho_tgt = wr_loc;
      end
      ho_go = keep;
    end

    // start a handover, possibly via an abort
    if (st_go) begin
      if (pend) begin
        n_pnext = st_tgt;
      end else if (cmd_busy) begin
        n_pnext = st_tgt;
        n_pab   = act_q;
      end else begin
        ho_go  = 1'b1;
        ho_tgt = st_tgt;
      end
    end

    // apply a handover
    if (ho_go) begin
      if (ho_tgt != act_q) begin
        n_chg = 1'b1;
        if (act_q != LOC_NONE) begin
          if ((ho_tgt != LOC_NONE) && n_seize[ho_tgt]) n_seized[act_q] = 1'b1;
          else n_req[act_q] = 1'b0;
        end
      end
      n_act = ho_tgt;
      if (ho_tgt != LOC_NONE) begin
        n_req[ho_tgt]   = 1'b0;
        n_seize[ho_tgt] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= '0;
      seize_q  <= '0;
      seized_q <= '0;
      act_q    <= LOC_NONE;
      pnext_q  <= LOC_NONE;
      pab_q    <= LOC_NONE;
      chg_q    <= 1'b0;
    end else begin
      req_q    <= n_req;
      seize_q  <= n_seize;
      seized_q <= n_seized;
      act_q    <= n_act;
      pnext_q  <= n_pnext;
      pab_q    <= n_pab;
      chg_q    <= n_chg;
    end
  end

  // owner stays put while an abort is outstanding
  assert_hold_during_abort_R12 : assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !abort_done) |=> $stable(act_q));

  // the abort bookkeeping returns to idle after completion
  assert_abort_clean_R12 : assert property (@(posedge clk) disable iff (!rst_n)
    done_take |=> (pnext_q == LOC_NONE) && (pab_q == LOC_NONE));

  // a change event always reflects a real owner move
  assert_change_moves_owner_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (act_q != $past(act_q)));

  generate
    for (genvar i = 0; i < NUM_LOC; i++) begin : g_chk
      // owner never carries a waiting request or outstanding seize
      assert_owner_clean_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == loc_t'(i)) |-> (!req_q[i] && !seize_q[i]));
      // override flag only appears together with an owner change
      assert_seized_on_handover_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seized_q[i]) |-> chg_q);
    end
  endgenerate

endmodule

// File: rtl/loc_arb_rdmux.sv
module loc_arb_rdmux
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic               reg_hit,
  input  loc_t               sel_loc,
  input  loc_t               act_q,
  input  logic [NUM_LOC-1:0] req_q,
  input  logic [NUM_LOC-1:0] seized_q,
  input  logic               est_in,
  output logic [7:0]         rdata
);

  logic [7:0] req8, seized8;

  assign req8    = 8'(req_q);
  assign seized8 = 8'(seized_q);

  always_comb begin
    rdata = 8'hFF;
    if (reg_hit) begin
      rdata           = 8'h00;
      rdata[B_VALID]  = 1'b1;
      rdata[B_ACTIVE] = (act_q == sel_loc);
      rdata[B_SEIZED] = seized8[sel_loc];
      rdata[B_SEIZE]  = 1'b0;
      rdata[B_PEND]   = others_set(req8, sel_loc);
      rdata[B_REQ]    = req8[sel_loc];
      rdata[B_EST]    = est_in;
    end
  end

endmodule

// File: rtl/loc_arb_top.sv
module loc_arb_top
  import loc_arb_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int LOC_LSB = 12,
  parameter int NUM_LOC = 5,
  parameter int HW_LOC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              hw_src,
  input  logic              est_in,
  input  logic              cmd_busy,
  input  logic              abort_done,
  output logic [7:0]        rdata,
  output logic              active_valid,
  output logic [2:0]        active_loc,
  output logic              loc_changed,
  output logic              abort_req,
  output logic [2:0]        abort_loc
);

  loc_t               sel_loc, act_q, pnext_q, pab_q;
  logic               reg_hit, acc_wr, chg_q;
  logic [NUM_LOC-1:0] req_q, seized_q;

  loc_arb_decode #(
    .ADDR_W (ADDR_W),
    .LOC_LSB(LOC_LSB),
    .NUM_LOC(NUM_LOC),
    .HW_LOC (HW_LOC)
  ) u_dec (
    .wr_en  (wr_en),
    .hw_src (hw_src),
    .addr   (addr),
    .sel_loc(sel_loc),
    .reg_hit(reg_hit),
    .acc_wr (acc_wr)
  );

  loc_arb_core #(
    .NUM_LOC(NUM_LOC)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_wr    (acc_wr),
    .wr_loc    (sel_loc),
    .wdata     (wdata),
    .cmd_busy  (cmd_busy),
    .abort_done(abort_done),
    .act_q     (act_q),
    .req_q     (req_q),
    .seized_q  (seized_q),
    .chg_q     (chg_q),
    .pnext_q   (pnext_q),
    .pab_q     (pab_q)
  );

  loc_arb_rdmux #(
    .NUM_LOC(NUM_LOC)
  ) u_rd (
    .reg_hit (reg_hit),
    .sel_loc (sel_loc),
    .act_q   (act_q),
    .req_q   (req_q),
    .seized_q(seized_q),
    .est_in  (est_in),
    .rdata   (rdata)
  );

  assign active_valid = (act_q != LOC_NONE);
  assign active_loc   = act_q;
  assign loc_changed  = chg_q;
  assign abort_req    = (pnext_q != LOC_NONE);
  assign abort_loc    = pab_q;

endmodule

// File: tb/tb_loc_arb_top.sv
`timescale 1ns/1ps
module tb_loc_arb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        hw_src = 1'b0;
  logic        est_in = 1'b1;
  logic        cmd_busy = 1'b0;
  logic        abort_done = 1'b0;
  logic [7:0]  rdata;
  logic        active_valid, loc_changed, abort_req;
  logic [2:0]  active_loc, abort_loc;

  loc_arb_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .hw_src(hw_src), .est_in(est_in), .cmd_busy(cmd_busy), .abort_done(abort_done),
    .rdata(rdata), .active_valid(active_valid), .active_loc(active_loc),
    .loc_changed(loc_changed), .abort_req(abort_req), .abort_loc(abort_loc)
  );

  always #2.5 clk = ~clk;

  int    vectors = 0;
  int    fails = 0;
  bit    finished = 0;
  bit    run_cmp = 0;
  string cur_req = "R1";

  // behavioural reference state, 7 means none
  int m_act, m_pnext, m_pab;
  bit m_chg;
  bit m_req[5];
  bit m_seize[5];
  bit m_seized[5];

  function automatic int model_rd(int a);
    int l, off, r;
    bit others;
    l = a >> 12;
    off = a & 12'hFFF;
    if (off != 0 || l > 4) return 8'hFF;
    others = 0;
    for (int c = 0; c < 5; c++) if (c != l && m_req[c]) others = 1;
    r = 8'h80;
    if (m_act == l) r = r | 8'h20;
    if (m_seized[l]) r = r | 8'h10;
    if (others) r = r | 8'h04;
    if (m_req[l]) r = r | 8'h02;
    if (est_in) r = r | 8'h01;
    return r;
  endfunction

  task automatic model_step();
    int l, off, ho, st, tgt, top;
    bit pend, ok, setn, accept;
    logic [7:0] v;
    l = int'(addr) >> 12;
    off = int'(addr) & 12'hFFF;
    pend = (m_pnext != 7);
    ok = wr_en && off == 0 && l < 5 && (l != 4 || hw_src);
    ho = -1;
    st = -1;
    m_chg = 0;
    if (pend && abort_done) begin
      ho = m_pnext; m_pnext = 7; m_pab = 7;
    end else if (ok) begin
      v = wdata; setn = 1; tgt = m_act;
      if (v[3]) begin v[1] = 0; v[5] = 0; end
      if (v[5]) begin
        if (m_act == l) begin
          if (!pend) begin
            top = -1;
            for (int c = 4; c >= 0; c--) if (m_req[c] && top < 0) top = c;
            if (top >= 0) begin setn = 0; st = top; end
            else tgt = 7;
          end
        end else m_req[l] = 0;
      end
      if (v[4]) m_seized[l] = 0;
      if (v[3]) begin
        accept = (m_act == 7 || l > m_act) && !m_seize[l];
        for (int c = l + 1; c < 5; c++) if (m_seize[c]) accept = 0;
        if (accept) begin
          for (int c = 0; c < l; c++) m_seize[c] = 0;
          m_seize[l] = 1; setn = 0; st = l;
        end
      end
      if (v[1] && m_act != l) begin
        if (m_act != 7 || pend) m_req[l] = 1;
        else tgt = l;
      end
      if (setn) ho = tgt;
    end
    if (st >= 0) begin
      if (pend) m_pnext = st;
      else if (cmd_busy) begin m_pnext = st; m_pab = m_act; end
      else ho = st;
    end
    if (ho >= 0) begin
      if (ho != m_act) begin
        m_chg = 1;
        if (m_act != 7) begin
          if (ho != 7 && m_seize[ho]) m_seized[m_act] = 1;
          else m_req[m_act] = 0;
        end
      end
      m_act = ho;
      if (ho != 7) begin m_req[ho] = 0; m_seize[ho] = 0; end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 7; m_pnext = 7; m_pab = 7; m_chg = 0;
      for (int c = 0; c < 5; c++) begin m_req[c] = 0; m_seize[c] = 0; m_seized[c] = 0; end
    end else model_step();
  end

  task automatic fail_line(string tag, string what, int got, int exp);
    fails++;
    $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", tag, what, got, exp, $time);
  endtask

  // per-cycle comparison against the reference
  always @(posedge clk) begin
    #1;
    if (rst_n && run_cmp && !finished) begin
      vectors++;
      if (int'(active_loc) != m_act) fail_line(cur_req, "active_loc", active_loc, m_act);
      if (active_valid != (m_act != 7)) fail_line(cur_req, "active_valid", active_valid, m_act != 7);
      if (loc_changed != m_chg) fail_line(cur_req, "loc_changed", loc_changed, m_chg);
      if (abort_req != (m_pnext != 7)) fail_line("R12", "abort_req", abort_req, m_pnext != 7);
      if (int'(abort_loc) != m_pab) fail_line("R12", "abort_loc", abort_loc, m_pab);
      if (int'(rdata) != model_rd(int'(addr))) fail_line("R2", "rdata", rdata, model_rd(int'(addr)));
    end
  end

  task automatic chk(string tag, string what, int got, int exp);
    vectors++;
    if (got != exp) fail_line(tag, what, got, exp);
  endtask

  task automatic wr(int loc, int off, logic [7:0] val, bit hw);
    @(negedge clk);
    addr = 15'((loc << 12) | off);
    wdata = val; hw_src = hw; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; hw_src = 1'b0;
  endtask

  task automatic rd_chk(string tag, int loc, int off, int exp);
    @(negedge clk);
    addr = 15'((loc << 12) | off);
    #1;
    chk(tag, "access read", int'(rdata), exp);
  endtask

  task automatic done_pulse();
    @(negedge clk); abort_done = 1'b1;
    @(negedge clk); abort_done = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    run_cmp = 1;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    chk("R1", "active_valid", active_valid, 0);
    chk("R1", "active_loc", active_loc, 7);
    chk("R1", "abort_loc", abort_loc, 7);
    chk("R1", "abort_req", abort_req, 0);
    rd_chk("R1", 0, 0, 8'h81);
    // R3 immediate grant
    cur_req = "R3";
    wr(2, 0, 8'h02, 0);
    chk("R3", "active_loc", active_loc, 2);
    chk("R3", "loc_changed", loc_changed, 1);
    @(negedge clk);
    chk("R3", "loc_changed pulse width", loc_changed, 0);
    // R4 waiting request, R2 pending bit
    cur_req = "R4";
    wr(0, 0, 8'h02, 0);
    rd_chk("R4", 0, 0, 8'h83);
    rd_chk("R2", 2, 0, 8'hA5);
    wr(3, 0, 8'h02, 0);
    // R5 release picks highest waiting
    cur_req = "R5";
    wr(2, 0, 8'h20, 0);
    chk("R5", "active_loc", active_loc, 3);
    rd_chk("R5", 2, 0, 8'h85);
    rd_chk("R5", 3, 0, 8'hA5);
    // R6 non-owner withdraws
    cur_req = "R6";
    wr(0, 0, 8'h20, 0);
    rd_chk("R6", 0, 0, 8'h81);
    // R5 release with none waiting
    cur_req = "R5";
    wr(3, 0, 8'h20, 0);
    chk("R5", "active_valid", active_valid, 0);
    // R7 seize from lower is ignored
    cur_req = "R7";
    wr(1, 0, 8'h02, 0);
    wr(0, 0, 8'h08, 0);
    chk("R7", "active_loc", active_loc, 1);
    wr(3, 0, 8'h02, 0);
    // R8 seize handover marks old owner
    cur_req = "R8";
    wr(2, 0, 8'h0A, 0);
    chk("R8", "active_loc", active_loc, 2);
    chk("R8", "loc_changed", loc_changed, 1);
    rd_chk("R8", 1, 0, 8'h95);
    rd_chk("R9", 2, 0, 8'hA5);
    // R10 seize write ignores request bit; clear override
    cur_req = "R10";
    wr(0, 0, 8'h0A, 0);
    rd_chk("R10", 0, 0, 8'h85);
    wr(1, 0, 8'h10, 0);
    rd_chk("R10", 1, 0, 8'h85);
    // R11 locality 4 gate
    cur_req = "R11";
    wr(4, 0, 8'h02, 0);
    rd_chk("R11", 4, 0, 8'h85);
    chk("R11", "active_loc", active_loc, 2);
    // R12 abort path with retarget
    cur_req = "R12";
    cmd_busy = 1'b1;
    wr(3, 0, 8'h08, 0);
    chk("R12", "abort_req", abort_req, 1);
    chk("R12", "abort_loc", abort_loc, 2);
    chk("R12", "active_loc", active_loc, 2);
    wr(4, 0, 8'h08, 1);
    cur_req = "R7";
    wr(3, 0, 8'h08, 0);
    cur_req = "R12";
    repeat (3) @(negedge clk);
    chk("R12", "active held", active_loc, 2);
    done_pulse();
    chk("R12", "active_loc", active_loc, 4);
    chk("R12", "loc_changed", loc_changed, 1);
    chk("R12", "abort_req", abort_req, 0);
    chk("R12", "abort_loc", abort_loc, 7);
    cmd_busy = 1'b0;
    rd_chk("R8", 2, 0, 8'h95);
    // R9 no event without a change
    cur_req = "R9";
    wr(4, 0, 8'h02, 1);
    chk("R9", "loc_changed", loc_changed, 0);
    chk("R9", "active_loc", active_loc, 4);
    // R13 unmapped space
    cur_req = "R13";
    wr(5, 0, 8'h02, 0);
    wr(0, 4, 8'h02, 0);
    rd_chk("R13", 0, 0, 8'h85);
    rd_chk("R13", 6, 0, 8'hFF);
    rd_chk("R13", 0, 4, 8'hFF);
    // R12 normal handover through abort
    cur_req = "R12";
    cmd_busy = 1'b1;
    wr(4, 0, 8'h20, 1);
    chk("R12", "abort_loc", abort_loc, 4);
    done_pulse();
    cmd_busy = 1'b0;
    chk("R12", "active_loc", active_loc, 3);
    rd_chk("R8", 4, 0, 8'h81);
    rd_chk("R9", 3, 0, 8'hA1);
    // randomised run checked by the reference every cycle
    cur_req = "R7";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_en = ($urandom % 3) == 0;
      addr = 15'((($urandom % 8 < 6) ? ($urandom % 5) : ($urandom % 8)) << 12 |
                 (($urandom % 10 == 0) ? 4 : 0));
      wdata = 8'($urandom);
      hw_src = 1'($urandom);
      est_in = ($urandom % 8) != 0;
      cmd_busy = 1'($urandom);
      abort_done = abort_req && (($urandom % 4) == 0);
    end
    @(negedge clk);
    wr_en = 1'b0; abort_done = 1'b0;
    repeat (2) @(negedge clk);
    summary();
  end

endmodule